// File: doc/BRIEF.md
# EDO DRAM Access Sequencer

This block sits between a host request port and a 1M x 4 extended-data-out DRAM whose 20-bit word address is multiplexed over a 10-bit bus. Each accepted request becomes a sequence of registered active-low strobes (row strobe, column strobe, write enable, output enable) plus a data-output enable. Every analog timing minimum is given as a parameter in clock cycles, rounded up. Each phase of the sequence holds until its counter runs out.

Reads sample the DRAM data pins a programmable number of cycles after the column strobe falls. The captured nibble goes back to the host with a one-cycle valid pulse. Writes use early-write ordering: the write enable falls and the data is driven before the column strobe drops, so the DRAM never drives the pins during a write. When the host sets the burst hint and the next request addresses the same row, the row stays open and only a new column cycle is run. The burst stops before the row-strobe low time would exceed its limit.

Refresh is requested by an outside scheduler. It is carried out as a column-before-row cycle, only while no row is open.

Top module: `edo_seq`

## Requirements
- R1: During and right after reset, ras_n, cas_n, we_n and oe_n are 1, while dq_oe, rd_valid, ref_ack and req_ready are 0.
- R2: The row half of the address, req_addr[19:10], is on mem_addr at least one cycle before ras_n falls and is unchanged at the fall. The column half, req_addr[9:0], is likewise set up and held for every cas_n fall.
- R3: For a read, dq_in is sampled exactly T_RD cycles after cas_n falls. The value appears on rd_data with rd_valid high for one cycle, and reads return in request order.
- R4: For a write, we_n is low, oe_n is high and dq_oe drives req_wdata on dq_out at least one cycle before cas_n falls, so the DRAM stores the request data.
- R5: If the current access carried req_burst=1, the next request is accepted at the end of the column-high phase when it targets the same row. It then runs as a further cas_n cycle with no new ras_n fall.
- R6: The row is closed (ras_n rises, cas_n already high) when the next request targets another row, or the open access had req_burst=0, or no request is pending.
- R7: ras_n never stays low for T_RAS_MAX cycles or more. A same-row burst that would run past the limit is split into several row openings.
- R8: ras_n stays high for at least T_RP cycles before each fall, including after reset, where req_ready stays 0 for the first T_RP cycles.
- R9: Within an open row, cas_n is high for exactly T_CP+1 cycles between consecutive column accesses.
- R10: A ref_req seen while idle wins over a pending request. cas_n falls one cycle before ras_n with we_n high, ras_n is held low for T_REF cycles, and ref_ack pulses for one cycle as both strobes rise. A refresh never starts while a row is open.
- R11: oe_n is low only for read accesses, and dq_oe and a low oe_n never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | Keep the row open for a following same-row request |
| req_addr | input | 20 | Word address, row in [19:10], column in [9:0] |
| req_wdata | input | 4 | Write data |
| rd_valid | output | 1 | One-cycle read-data strobe |
| rd_data | output | 4 | Read data |
| ref_req | input | 1 | Refresh request from the scheduler |
| ref_ack | output | 1 | One-cycle pulse when a refresh finishes |
| mem_addr | output | 10 | Multiplexed DRAM address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | DRAM output enable, active low |
| dq_oe | output | 1 | Controller drives the DQ pins |
| dq_out | output | 4 | Data driven onto DQ |
| dq_in | input | 4 | Data read from DQ |

## Verification
The bench models the DRAM at its pins. It latches the row on the row-strobe fall and the column on the column-strobe fall, and it holds read data after the column strobe rises until both strobes are high, which is how extended-data-out parts behave. The corner cases are:
- Same-row bursts. A design that reopened the row would show extra row-strobe falls.
- Bursts long enough to hit the row-low limit. A design with no split would hold the row open past T_RAS_MAX.
- Row changes and a cleared hint. A design that ignored them would read the wrong row.
- A refresh request that arrives together with a host request, and one that arrives in mid-burst. A design with the wrong priority or open-row check would refresh with a row open or delay the refresh.
- The capture delay. Sampling at the wrong cycle returns undriven data.

// File: rtl/edo_seq.sv
module edo_seq #(
  parameter int AW        = 20,
  parameter int DW        = 4,
  parameter int T_RP      = 4,
  parameter int T_RCD     = 4,
  parameter int T_CAS     = 2,
  parameter int T_CP      = 1,
  parameter int T_RD      = 3,
  parameter int T_REF     = 7,
  parameter int T_RAS_MAX = 12500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic          req_burst,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  input  logic          ref_req,
  output logic          ref_ack,
  output logic [AW/2-1:0] mem_addr,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic          oe_n,
  output logic          dq_oe,
  output logic [DW-1:0] dq_out,
  input  logic [DW-1:0] dq_in
);
  localparam int HW     = AW / 2;
  localparam int M1     = T_RP > T_RCD ? T_RP : T_RCD;
  localparam int M2     = M1 > T_CAS ? M1 : T_CAS;
  localparam int M3     = M2 > T_CP ? M2 : T_CP;
  localparam int M4     = M3 > T_REF ? M3 : T_REF;
  localparam int CW     = $clog2(M4 + 1);
  localparam int PW     = $clog2(T_RD + 1);
  localparam int RW     = $clog2(T_RAS_MAX + 1);
  localparam int T_BEAT = 1 + T_CAS + T_CP;

  typedef enum logic [3:0] {
    S_PRE, S_IDLE, S_ROW, S_RCD, S_CLO, S_CHI, S_COL, S_REFC, S_REFR
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [PW-1:0] cap;
  logic [RW-1:0] ras_cnt;
  logic [HW-1:0] row_q, col_q;
  logic          wr_q, burst_q;
  logic          go;

  // R5 R6 R7: stay in the row only for a hinted same-row request that fits the limit
  assign go = burst_q && (req_addr[AW-1:HW] == row_q) &&
              (int'(ras_cnt) + T_BEAT + 2 <= T_RAS_MAX);
  // R10: refresh wins in idle
  assign req_ready = (st == S_IDLE && !ref_req) || (st == S_CHI && cnt == '0 && go);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_PRE;  cnt <= CW'(T_RP - 1);  cap <= '0;  ras_cnt <= '0;
      ras_n <= 1'b1;  cas_n <= 1'b1;  we_n <= 1'b1;  oe_n <= 1'b1;
      dq_oe <= 1'b0;  dq_out <= '0;  mem_addr <= '0;
      row_q <= '0;  col_q <= '0;  wr_q <= 1'b0;  burst_q <= 1'b0;
      rd_valid <= 1'b0;  rd_data <= '0;  ref_ack <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      ref_ack  <= 1'b0;
      if (cnt != '0) cnt <= cnt - 1'b1;
      ras_cnt <= ras_n ? '0 : (ras_cnt == RW'(T_RAS_MAX) ? ras_cnt : ras_cnt + 1'b1);
      // R3: capture T_RD cycles after the column strobe fall
      if (cap != '0) cap <= cap - 1'b1;
      if (cap == PW'(1)) begin
        rd_valid <= 1'b1;
        rd_data  <= dq_in;
      end
      case (st)
        S_PRE: if (cnt == '0) st <= S_IDLE;
        S_IDLE:
          if (ref_req) begin
            st <= S_REFC;  cas_n <= 1'b0;
          end else if (req_valid) begin
            st <= S_ROW;
            mem_addr <= req_addr[AW-1:HW];
            row_q <= req_addr[AW-1:HW];  col_q <= req_addr[HW-1:0];
            wr_q <= req_write;  burst_q <= req_burst;
            we_n <= !req_write;  oe_n <= req_write;
            dq_oe <= req_write;  dq_out <= req_wdata;
          end
        S_ROW: begin
          st <= S_RCD;  ras_n <= 1'b0;  cnt <= CW'(T_RCD - 1);
        end
        S_RCD: begin
          mem_addr <= col_q;
          if (cnt == '0) begin
            st <= S_CLO;  cas_n <= 1'b0;  cnt <= CW'(T_CAS - 1);
            if (!wr_q) cap <= PW'(T_RD);
          end
        end
        S_CLO:
          if (cnt == '0) begin
            st <= S_CHI;  cas_n <= 1'b1;  cnt <= CW'(T_CP - 1);
          end
        S_CHI:
          if (cnt == '0) begin
            if (go && req_valid) begin
              st <= S_COL;
              mem_addr <= req_addr[HW-1:0];
              col_q <= req_addr[HW-1:0];
              wr_q <= req_write;  burst_q <= req_burst;
              we_n <= !req_write;  oe_n <= req_write;
              dq_oe <= req_write;  dq_out <= req_wdata;
            end else begin
              st <= S_PRE;  ras_n <= 1'b1;  we_n <= 1'b1;  oe_n <= 1'b1;
              dq_oe <= 1'b0;  cnt <= CW'(T_RP - 1);
            end
          end
        S_COL: begin
          st <= S_CLO;  cas_n <= 1'b0;  cnt <= CW'(T_CAS - 1);
          if (!wr_q) cap <= PW'(T_RD);
        end
        S_REFC: begin
          st <= S_REFR;  ras_n <= 1'b0;  cnt <= CW'(T_REF - 1);
        end
        S_REFR:
          if (cnt == '0) begin
            st <= S_PRE;  ras_n <= 1'b1;  cas_n <= 1'b1;  ref_ack <= 1'b1;
            cnt <= CW'(T_RP - 1);
          end
        default: st <= S_PRE;
      endcase
    end
  end
endmodule

// File: rtl/edo_seq_chk.sv
module edo_seq_chk #(
  parameter int HW        = 10,
  parameter int T_RP      = 4,
  parameter int T_RAS_MAX = 12500
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ras_n,
  input logic          cas_n,
  input logic          we_n,
  input logic          oe_n,
  input logic          dq_oe,
  input logic [HW-1:0] mem_addr,
  input logic          rd_valid,
  input logic          ref_ack
);
  logic [31:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= '0;
    end else begin
      lo_cnt <= ras_n ? '0 : lo_cnt + 1;
      hi_cnt <= !ras_n ? '0 : (hi_cnt == 32'hffff_ffff ? hi_cnt : hi_cnt + 1);
    end
  end

  assert_row_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) && cas_n |-> $stable(mem_addr));
  assert_col_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) && !ras_n |-> $stable(mem_addr));
  assert_early_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) && !we_n |-> $past(!we_n) && dq_oe && oe_n);
  assert_one_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  assert_close_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> cas_n);
  assert_ras_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> lo_cnt < T_RAS_MAX);
  assert_precharge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> hi_cnt >= T_RP);
  assert_cbr_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) && !cas_n |-> we_n && $past(!cas_n));
  assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ack |=> !ref_ack);
  assert_no_fight_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n);
endmodule

bind edo_seq edo_seq_chk #(.HW(HW), .T_RP(T_RP), .T_RAS_MAX(T_RAS_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .oe_n(oe_n), .dq_oe(dq_oe), .mem_addr(mem_addr), .rd_valid(rd_valid),
  .ref_ack(ref_ack)
);

// File: tb/tb_edo_seq.sv
`timescale 1ns/1ps
module tb_edo_seq;
  localparam int T_RP = 4, T_CP = 1, T_RD = 3, T_RAS_MAX = 20;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_burst = 0, ref_req = 0;
  logic [19:0] req_addr = '0;
  logic [3:0]  req_wdata = '0, dq_in = 'x;
  logic req_ready, rd_valid, ref_ack, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [3:0] rd_data, dq_out;
  logic [9:0] mem_addr;

  edo_seq #(.T_RAS_MAX(T_RAS_MAX)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_burst(req_burst), .req_addr(req_addr),
    .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .ref_req(ref_req), .ref_ack(ref_ack), .mem_addr(mem_addr), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n), .dq_oe(dq_oe), .dq_out(dq_out),
    .dq_in(dq_in));

  always #4 clk = ~clk;

  int total = 0, fails = 0, cyc = 0;
  bit done = 0;
  logic [3:0] mem [256];
  logic [3:0] rq [$];
  logic [3:0] lat;
  logic [9:0] row_m, prev_addr;
  logic prev_ras = 1, prev_cas = 1, prev_we = 1, lat_ok = 0, chi_valid = 0;
  int rasf, casf, cbr, cbr_bad, addr_bad, wr_bad, oe_bad, acks;
  int chi, min_chi, pre_run, min_pre = 1000, lo_run, max_lo;
  int rcasf_cyc, rd_lat, ack_cyc, rasf_cyc, last_casf_cyc;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (dq_oe && !oe_n) oe_bad++;
      if (prev_ras && !ras_n) begin
        if (pre_run < min_pre) min_pre = pre_run;
        if (cas_n) begin
          rasf++; rasf_cyc = cyc; row_m = mem_addr;
          if (mem_addr !== prev_addr) addr_bad++;
          chi = 0; chi_valid = 0;
        end else begin
          cbr++; if (!we_n) cbr_bad++;
        end
      end
      if (prev_cas && !cas_n && !ras_n) begin
        casf++; last_casf_cyc = cyc;
        if (mem_addr !== prev_addr) addr_bad++;
        if (chi_valid && chi < min_chi) min_chi = chi;
        chi = 0; chi_valid = 1;
        if (!we_n) begin
          if (prev_we || !dq_oe || !oe_n) wr_bad++;
          mem[{row_m[3:0], mem_addr[3:0]}] = dq_out;
        end else begin
          lat = mem[{row_m[3:0], mem_addr[3:0]}]; lat_ok = 1; rcasf_cyc = cyc;
        end
      end
      if (cas_n && !ras_n) chi++;
      if (ras_n) begin pre_run++; lo_run = 0; end
      else begin pre_run = 0; lo_run++; if (lo_run > max_lo) max_lo = lo_run; end
      if (ras_n && cas_n) lat_ok = 0;
      dq_in = (!oe_n && we_n && lat_ok && !(ras_n && cas_n)) ? lat : 4'bx;
      if (rd_valid) begin rq.push_back(rd_data); rd_lat = cyc - rcasf_cyc; end
      if (ref_ack) begin acks++; ack_cyc = cyc; end
    end
    prev_ras = ras_n; prev_cas = cas_n; prev_we = we_n; prev_addr = mem_addr;
  end

  task automatic chk(input string r, input int act, input int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic clr();
    rasf = 0; casf = 0; cbr = 0; acks = 0; min_chi = 99; max_lo = 0;
    rq.delete();
  endtask

  task automatic settle();
    repeat (30) @(negedge clk);
    #2;
  endtask

  task automatic send(input logic [19:0] a, input logic w, input logic [3:0] d, input logic b);
    req_addr = a; req_write = w; req_wdata = d; req_burst = b; req_valid = 1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk); #1;
    req_valid = 0;
  endtask

  function automatic logic [19:0] ad(input int row, input int col);
    return {10'(row), 10'(col)};
  endfunction

  task automatic t_reset();
    chk("R1 ras_n", ras_n, 1); chk("R1 cas_n", cas_n, 1);
    chk("R1 we_n/oe_n", {we_n, oe_n}, 2'b11);
    chk("R1 dq_oe/rd_valid/ref_ack", {dq_oe, rd_valid, ref_ack}, 0);
    chk("R1 req_ready", req_ready, 0);
    repeat (T_RP - 1) @(negedge clk);
    #1 chk("R8 ready held in reset precharge", req_ready, 0);
    @(negedge clk);
    #1 chk("R8 ready after reset precharge", req_ready, 1);
  endtask

  task automatic t_single();
    clr();
    send(ad(5, 3), 1, 4'h9, 0);
    settle();
    chk("R4 early write stored", mem[8'h53], 4'h9);
    chk("R4 no read pulse on write", rq.size(), 0);
    send(ad(5, 3), 0, 4'h0, 0);
    settle();
    chk("R3 one read returned", rq.size(), 1);
    if (rq.size() == 1) chk("R3 read data", rq[0], 4'h9);
    chk("R3 capture delay", rd_lat, T_RD);
    chk("R2 address setup at strobes", addr_bad, 0);
    chk("R4 write ordering", wr_bad, 0);
  endtask

  task automatic t_burst();
    logic [3:0] v [4] = '{4'hA, 4'h5, 4'hC, 4'h3};
    clr();
    for (int k = 0; k < 4; k++) send(ad(7, k), 1, v[k], 1);
    settle();
    chk("R5 burst write single row open", rasf, 1);
    chk("R5 burst write column cycles", casf, 4);
    for (int k = 0; k < 4; k++) chk("R4 burst write data", mem[8'h70 + k], v[k]);
    clr();
    for (int k = 0; k < 4; k++) send(ad(7, k), 0, 4'h0, 1);
    settle();
    chk("R5 burst read single row open", rasf, 1);
    chk("R3 burst read count", rq.size(), 4);
    for (int k = 0; k < 4 && k < rq.size(); k++) chk("R3 burst read order", rq[k], v[k]);
    chk("R9 column high between beats", min_chi, T_CP + 1);
  endtask

  task automatic t_row_change();
    clr();
    send(ad(7, 0), 0, 0, 1);
    send(ad(5, 3), 0, 0, 1);
    settle();
    chk("R6 new row reopens", rasf, 2);
    chk("R6 data after row change", {rq.size() == 2 ? rq[0] : 4'hx, rq.size() == 2 ? rq[1] : 4'hx}, 8'hA9);
    clr();
    send(ad(7, 1), 0, 0, 0);
    send(ad(7, 2), 0, 0, 0);
    settle();
    chk("R6 cleared hint closes row", rasf, 2);
    chk("R6 data with cleared hint", {rq.size() == 2 ? rq[0] : 4'hx, rq.size() == 2 ? rq[1] : 4'hx}, 8'h5C);
  endtask

  task automatic t_ras_limit();
    logic [3:0] e [6] = '{4'hA, 4'h5, 4'hC, 4'h3, 4'hA, 4'h5};
    clr();
    for (int k = 0; k < 6; k++) send(ad(7, k % 4), 0, 0, 1);
    settle();
    chk("R7 long burst split", rasf, 2);
    chk("R7 row low below limit", max_lo < T_RAS_MAX, 1);
    chk("R7 split burst count", rq.size(), 6);
    for (int k = 0; k < 6 && k < rq.size(); k++) chk("R7 split burst data", rq[k], e[k]);
    chk("R8 precharge minimum", min_pre >= T_RP, 1);
  endtask

  task automatic t_ref_priority();
    clr();
    fork
      begin ref_req = 1; while (!ref_ack) @(negedge clk); #1 ref_req = 0; end
      begin @(negedge clk); #1 send(ad(5, 3), 0, 0, 0); end
    join
    settle();
    chk("R10 one refresh", cbr, 1);
    chk("R10 one ack", acks, 1);
    chk("R10 refresh before request", ack_cyc < rasf_cyc, 1);
    chk("R10 write enable high in refresh", cbr_bad, 0);
    chk("R10 request served after refresh", rq.size() == 1 ? rq[0] : 4'hx, 4'h9);
  endtask

  task automatic t_ref_in_burst();
    clr();
    fork
      begin for (int k = 0; k < 4; k++) send(ad(7, k), 0, 0, 1); end
      begin repeat (3) @(negedge clk); #1 ref_req = 1;
            while (!ref_ack) @(negedge clk); #1 ref_req = 0; end
    join
    settle();
    chk("R10 burst not broken by refresh", rasf, 1);
    chk("R10 refresh after row closes", ack_cyc > last_casf_cyc, 1);
    chk("R10 refresh done", cbr, 1);
    chk("R5 burst data intact", rq.size(), 4);
    chk("R11 no output contention", oe_bad, 0);
    chk("R11 oe high during writes", wr_bad, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    t_reset();
    settle();
    t_single();
    t_burst();
    t_row_change();
    t_ras_limit();
    t_ref_priority();
    t_ref_in_burst();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule